// File: doc/BRIEF.md
# Miss-Address Stride Prefetcher

This block sits beside a first-level data cache and looks only at the stream of addresses that miss in it. Each miss comes with a flag that says whether it was a load or a store. No program counter and no branch information are used. Loads and stores each keep their own short history of recent misses. A new miss is compared with the history of its own kind. When three misses of that kind are equally spaced, with a nonzero stride of at most 4 KiB, the stride counts as steady. It is then placed in a small stride table, and from that point the table predicts the stream.

A later miss that lands exactly one stride past a table entry's last address advances that entry and produces a prefetch address. Normally the prefetch is one stride ahead. The block watches for references that run faster than the memory side accepts prefetches. If an entry is matched again while its previous request is still waiting for a grant, that entry's look-ahead distance grows, up to four strides. A miss of the same kind that lands near an entry but off its stride removes that entry.

Prefetch requests leave on a valid/ready port that holds one request at a time. The request stays valid with a stable address until `pf_ready` is high at a clock edge. A newer prediction replaces a request that has not been granted yet, so back-pressure never stalls the miss input. The miss input is a plain strobe and has no ready signal.

Top module: `stride_prefetcher`

## Requirements
- R1: While reset is asserted and after it is released, `pf_valid` is 0 until a miss produces a request.
- R2: Three misses of the same kind at addresses a, a+d and a+2d, with d nonzero and |d| no more than 4096, allocate a table entry. The cycle after the third miss, `pf_valid` is 1 with `pf_addr` = a+3d. Two misses alone produce no request.
- R3: Load misses (`miss_is_store`=0) and store misses (`miss_is_store`=1) are tracked apart. Equally spaced misses that alternate in kind produce no request, and a stream of store misses alone is detected like a stream of loads.
- R4: A stride of exactly 4096 bytes is accepted. A stride of 4100 bytes is never detected. Negative strides are detected, with all addresses taken modulo 2^32.
- R5: A miss of the entry's kind that equals the entry's last address plus its stride updates the last address. The next cycle it requests the miss address plus stride times the entry's look-ahead.
- R6: Look-ahead starts at 1 on allocation. It grows by 1, to at most 4, when a matching miss arrives while the current request came from the same entry and is not granted in that cycle. A grant in the same cycle as the miss leaves it unchanged.
- R7: A miss of the entry's kind that matches no entry invalidates that entry if it lies nonzero and within 4096 bytes of the entry's last address but off its stride. Such a miss issues no request of its own, and a pending request is kept.
- R8: The table has 4 entries. Allocation fills an invalid entry first, otherwise it replaces the least recently allocated-or-matched entry.
- R9: `pf_valid` stays high with a stable `pf_addr` until `pf_ready` is high at a clock edge. After a grant with no new miss, `pf_valid` falls on the next cycle.
- R10: A new request overwrites a pending, ungranted one. Only one request is ever held.
- R11: A request becomes valid only in the cycle after a miss. With no miss, an idle port stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A first-level data cache miss is presented this cycle |
| miss_addr | input | 32 | Byte address of the miss |
| miss_is_store | input | 1 | 1 for a store miss, 0 for a load miss |
| pf_valid | output | 1 | A prefetch request is held |
| pf_ready | input | 1 | Memory side accepts the held request at this edge |
| pf_addr | output | 32 | Prefetch byte address |

## Verification
A corrupted history or stride table shows up at the prefetch port as a wrong address or a missing request, one cycle after the miss that should have used it. Lost look-ahead state is exposed by chains of matching misses held under back-pressure, where each step must move the requested address a further stride out. A bad replacement choice or a missed invalidation stays hidden until the affected stream is touched again. The sequences therefore revisit evicted and broken streams on purpose, and the resulting address separates a surviving entry from a freshly allocated one.

// File: rtl/stride_pf_pkg.sv
package stride_pf_pkg;
  typedef enum logic {
    KIND_LOAD  = 1'b0,
    KIND_STORE = 1'b1
  } miss_kind_e;

  localparam int NUM_KINDS = 2;
endpackage

// File: rtl/stride_pf_history.sv
module stride_pf_history #(
  parameter int AW         = 32,
  parameter int DEPTH      = 8,
  parameter int MAX_STRIDE = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] addr,
  output logic          found,
  output logic [AW-1:0] stride
);
  localparam logic [AW-1:0] MAX_W = AW'(MAX_STRIDE);

  logic [AW-1:0] hist [DEPTH];
  logic          hvld [DEPTH];

  function automatic logic stride_ok(input logic [AW-1:0] d);
    logic [AW-1:0] mag;
    mag = d[AW-1] ? (~d + 1'b1) : d;
    return (d != '0) && (mag <= MAX_W);
  endfunction

  // smallest i (newest partner) first, then smallest j
  always_comb begin
    found  = 1'b0;
    stride = '0;
    for (int i = 0; i < DEPTH; i++) begin
      for (int j = i + 1; j < DEPTH; j++) begin
        if (!found && hvld[i] && hvld[j] &&
            stride_ok(addr - hist[i]) &&
            ((hist[i] - hist[j]) == (addr - hist[i]))) begin
          found  = 1'b1;
          stride = addr - hist[i];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) begin
        hist[k] <= '0;
        hvld[k] <= 1'b0;
      end
    end else if (push) begin
      hist[0] <= addr;
      hvld[0] <= 1'b1;
      for (int k = 1; k < DEPTH; k++) begin
        hist[k] <= hist[k-1];
        hvld[k] <= hvld[k-1];
      end
    end
  end
endmodule

// File: rtl/stride_pf_table.sv
module stride_pf_table #(
  parameter int AW         = 32,
  parameter int ENTRIES    = 4,
  parameter int MAX_STRIDE = 4096,
  parameter int LA_MAX     = 4
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   miss_valid,
  input  logic [AW-1:0]                          miss_addr,
  input  logic                                   miss_store,
  input  logic                                   det_found,
  input  logic [AW-1:0]                          det_stride,
  input  logic                                   pend_live,
  input  logic [((ENTRIES>1)?$clog2(ENTRIES):1)-1:0] pend_idx,
  output logic                                   req_valid,
  output logic [AW-1:0]                          req_addr,
  output logic [((ENTRIES>1)?$clog2(ENTRIES):1)-1:0] req_idx
);
  localparam int IW  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int LAW = $clog2(LA_MAX + 1);
  localparam logic [AW-1:0] MAX_W = AW'(MAX_STRIDE);

  logic [AW-1:0]  last [ENTRIES];
  logic [AW-1:0]  strd [ENTRIES];
  logic [LAW-1:0] la   [ENTRIES];
  logic [IW-1:0]  age  [ENTRIES];
  logic           vld  [ENTRIES];
  logic           kind [ENTRIES];

  logic           any_hit, alloc, vfound;
  logic [IW-1:0]  hit_idx, victim, touch;
  logic [LAW-1:0] new_la;
  logic [AW-1:0]  step;
  logic           brk [ENTRIES];

  function automatic logic near(input logic [AW-1:0] d);
    logic [AW-1:0] mag;
    mag = d[AW-1] ? (~d + 1'b1) : d;
    return (d != '0) && (mag <= MAX_W);
  endfunction

  always_comb begin
    any_hit = 1'b0;
    hit_idx = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (!any_hit && miss_valid && vld[e] && (kind[e] == miss_store) &&
          (miss_addr == last[e] + strd[e])) begin
        any_hit = 1'b1;
        hit_idx = IW'(e);
      end
    end
    for (int e = 0; e < ENTRIES; e++) begin
      brk[e] = miss_valid && !any_hit && vld[e] && (kind[e] == miss_store) &&
               near(miss_addr - last[e]);
    end
  end

  always_comb begin
    vfound = 1'b0;
    victim = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (!vfound && !vld[e]) begin
        vfound = 1'b1;
        victim = IW'(e);
      end
    end
    if (!vfound) begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (age[e] == IW'(ENTRIES - 1)) victim = IW'(e);
      end
    end
  end

  always_comb begin
    alloc  = miss_valid && !any_hit && det_found;
    new_la = la[hit_idx];
    if (pend_live && (pend_idx == hit_idx) && (la[hit_idx] < LAW'(LA_MAX)))
      new_la = la[hit_idx] + 1'b1;
    step      = strd[hit_idx] * AW'(new_la);
    req_valid = any_hit || alloc;
    req_addr  = any_hit ? (miss_addr + step) : (miss_addr + det_stride);
    touch     = any_hit ? hit_idx : victim;
    req_idx   = touch;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) begin
        last[e] <= '0;
        strd[e] <= '0;
        la[e]   <= LAW'(1);
        vld[e]  <= 1'b0;
        kind[e] <= 1'b0;
        age[e]  <= IW'(e);
      end
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (brk[e]) vld[e] <= 1'b0;
      end
      if (any_hit) begin
        last[hit_idx] <= miss_addr;
        la[hit_idx]   <= new_la;
      end else if (alloc) begin
        last[victim] <= miss_addr;
        strd[victim] <= det_stride;
        la[victim]   <= LAW'(1);
        vld[victim]  <= 1'b1;
        kind[victim] <= miss_store;
      end
      if (any_hit || alloc) begin
        for (int e = 0; e < ENTRIES; e++) begin
          if (IW'(e) == touch) age[e] <= '0;
          else if (age[e] < age[touch]) age[e] <= age[e] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/stride_prefetcher.sv
module stride_prefetcher #(
  parameter int AW         = 32,
  parameter int HIST_DEPTH = 8,
  parameter int ENTRIES    = 4,
  parameter int MAX_STRIDE = 4096,
  parameter int LA_MAX     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          miss_valid,
  input  logic [AW-1:0] miss_addr,
  input  logic          miss_is_store,
  output logic          pf_valid,
  input  logic          pf_ready,
  output logic [AW-1:0] pf_addr
);
  import stride_pf_pkg::*;

  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic          kind_found  [NUM_KINDS];
  logic [AW-1:0] kind_stride [NUM_KINDS];
  logic          det_found;
  logic [AW-1:0] det_stride;
  logic          req_valid;
  logic [AW-1:0] req_addr;
  logic [IW-1:0] req_idx, pf_src;

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_hist
    stride_pf_history #(
      .AW(AW), .DEPTH(HIST_DEPTH), .MAX_STRIDE(MAX_STRIDE)
    ) u_hist (
      .clk    (clk),
      .rst_n  (rst_n),
      .push   (miss_valid && (miss_is_store == miss_kind_e'(k))),
      .addr   (miss_addr),
      .found  (kind_found[k]),
      .stride (kind_stride[k])
    );
  end

  assign det_found  = miss_is_store ? kind_found[KIND_STORE] : kind_found[KIND_LOAD];
  assign det_stride = miss_is_store ? kind_stride[KIND_STORE] : kind_stride[KIND_LOAD];

  stride_pf_table #(
    .AW(AW), .ENTRIES(ENTRIES), .MAX_STRIDE(MAX_STRIDE), .LA_MAX(LA_MAX)
  ) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_valid (miss_valid),
    .miss_addr  (miss_addr),
    .miss_store (miss_is_store),
    .det_found  (det_found),
    .det_stride (det_stride),
    .pend_live  (pf_valid && !pf_ready),
    .pend_idx   (pf_src),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_idx    (req_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf_valid <= 1'b0;
      pf_addr  <= '0;
      pf_src   <= '0;
    end else if (req_valid) begin
      pf_valid <= 1'b1;
      pf_addr  <= req_addr;
      pf_src   <= req_idx;
    end else if (pf_ready) begin
      pf_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/stride_pf_checker.sv
module stride_pf_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          miss_valid,
  input logic          pf_valid,
  input logic          pf_ready,
  input logic [AW-1:0] pf_addr
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> !pf_valid);

  assert_hold_until_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && !pf_ready |=> pf_valid);

  assert_addr_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && !pf_ready && !miss_valid |=> $stable(pf_addr));

  assert_drain_after_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && pf_ready && !miss_valid |=> !pf_valid);

  assert_no_spurious_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !pf_valid && !miss_valid |=> !pf_valid);
endmodule

bind stride_prefetcher stride_pf_checker #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .miss_valid (miss_valid),
  .pf_valid   (pf_valid),
  .pf_ready   (pf_ready),
  .pf_addr    (pf_addr)
);

// File: tb/stride_prefetcher_test.sv
module stride_prefetcher_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid = 1'b0;
  logic [31:0] miss_addr = '0;
  logic        miss_is_store = 1'b0;
  logic        pf_ready = 1'b0;
  logic        pf_valid;
  logic [31:0] pf_addr;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  stride_prefetcher uut (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .miss_is_store(miss_is_store), .pf_valid(pf_valid), .pf_ready(pf_ready),
    .pf_addr(pf_addr)
  );

  task automatic expect_pf(input logic ev, input logic [31:0] ea, input string req);
    checks++;
    if (pf_valid !== ev || (ev && pf_addr !== ea)) begin
      fails++;
      $display("FAIL %s: got valid=%0b addr=%h, expected valid=%0b addr=%h",
               req, pf_valid, pf_addr, ev, ea);
    end
  endtask

  task automatic send(input logic [31:0] a, input logic st, input logic rdy);
    @(negedge clk);
    miss_valid = 1'b1; miss_addr = a; miss_is_store = st; pf_ready = rdy;
    @(negedge clk);
    miss_valid = 1'b0; pf_ready = 1'b0;
  endtask

  task automatic grant();
    @(negedge clk); pf_ready = 1'b1;
    @(negedge clk); pf_ready = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
  endtask

  localparam logic [31:0] A = 32'h0000_1000;
  localparam logic [31:0] Y = 32'h0040_0000;
  localparam logic [31:0] C = 32'h0080_0000;
  localparam logic [31:0] D = 32'h0100_0000;
  localparam logic [31:0] E = 32'h0200_0000;
  localparam logic [31:0] F = 32'h0300_0000;
  localparam logic [31:0] G = 32'h0400_0000;

  initial begin
    idle(3);
    expect_pf(1'b0, '0, "R1 in reset");
    rst_n = 1'b1;
    idle(2);
    expect_pf(1'b0, '0, "R1 after reset");

    // R2 detection of a +64 load stream
    send(A, 1'b0, 1'b0);
    send(A + 64, 1'b0, 1'b0);
    expect_pf(1'b0, '0, "R2 two misses");
    send(A + 128, 1'b0, 1'b0);
    expect_pf(1'b1, A + 192, "R2 third miss");
    idle(3);
    expect_pf(1'b1, A + 192, "R9 hold under back-pressure");
    grant();
    expect_pf(1'b0, '0, "R9 drain after grant");
    idle(2);
    expect_pf(1'b0, '0, "R11 idle stays idle");

    // R5/R6/R10 matching chain with growing look-ahead
    send(A + 192, 1'b0, 1'b0);
    expect_pf(1'b1, A + 256, "R5 match la1");
    send(A + 256, 1'b0, 1'b0);
    expect_pf(1'b1, A + 384, "R6 R10 la2 overwrite");
    send(A + 320, 1'b0, 1'b0);
    expect_pf(1'b1, A + 512, "R6 la3");
    send(A + 384, 1'b0, 1'b0);
    expect_pf(1'b1, A + 640, "R6 la4");
    send(A + 448, 1'b0, 1'b0);
    expect_pf(1'b1, A + 704, "R6 la saturates at 4");

    // R7 break invalidates; pending request kept
    send(A + 488, 1'b0, 1'b0);
    expect_pf(1'b1, A + 704, "R7 break issues nothing");
    send(A + 512, 1'b0, 1'b0);
    expect_pf(1'b1, A + 576, "R7 entry gone, fresh la1");
    grant();

    // R3 store stream and mixed kinds
    send(Y, 1'b1, 1'b0);
    send(Y + 32, 1'b1, 1'b0);
    expect_pf(1'b0, '0, "R3 two stores");
    send(Y + 64, 1'b1, 1'b0);
    expect_pf(1'b1, Y + 96, "R3 store stream");
    grant();
    send(C, 1'b0, 1'b0);
    send(C + 16, 1'b1, 1'b0);
    send(C + 32, 1'b0, 1'b0);
    expect_pf(1'b0, '0, "R3 mixed kinds not a stride");

    // R4 stride limits and negative strides
    do_reset();
    expect_pf(1'b0, '0, "R1 second reset");
    send(D, 1'b0, 1'b0);
    send(D + 4096, 1'b0, 1'b0);
    send(D + 8192, 1'b0, 1'b0);
    expect_pf(1'b1, D + 12288, "R4 stride 4096 accepted");
    grant();
    send(E, 1'b0, 1'b0);
    send(E + 4100, 1'b0, 1'b0);
    send(E + 8200, 1'b0, 1'b0);
    expect_pf(1'b0, '0, "R4 stride 4100 rejected");
    send(F, 1'b0, 1'b0);
    send(F - 32, 1'b0, 1'b0);
    send(F - 64, 1'b0, 1'b0);
    expect_pf(1'b1, F - 96, "R4 negative stride");
    send(F - 96, 1'b0, 1'b1);
    expect_pf(1'b1, F - 128, "R6 same-cycle grant keeps la1");
    send(F - 128, 1'b0, 1'b0);
    expect_pf(1'b1, F - 192, "R6 negative la2");
    grant();

    // R8 replacement order
    do_reset();
    for (int k = 0; k < 4; k++) begin
      send(G + 32'(k) * 32'h1_0000, 1'b0, 1'b0);
      send(G + 32'(k) * 32'h1_0000 + 16, 1'b0, 1'b0);
      send(G + 32'(k) * 32'h1_0000 + 32, 1'b0, 1'b0);
      expect_pf(1'b1, G + 32'(k) * 32'h1_0000 + 48, "R8 fill entry");
      grant();
    end
    send(G + 48, 1'b0, 1'b0);
    expect_pf(1'b1, G + 64, "R5 touch oldest");
    grant();
    send(G + 32'h4_0000, 1'b0, 1'b0);
    send(G + 32'h4_0000 + 16, 1'b0, 1'b0);
    send(G + 32'h4_0000 + 32, 1'b0, 1'b0);
    expect_pf(1'b1, G + 32'h4_0000 + 48, "R8 fifth stream");
    grant();
    send(G + 32'h1_0000 + 48, 1'b0, 1'b0);
    expect_pf(1'b0, '0, "R8 LRU entry evicted");
    send(G + 32'h2_0000 + 48, 1'b0, 1'b0);
    expect_pf(1'b1, G + 32'h2_0000 + 64, "R8 other entry kept");
    grant();
    send(G + 64, 1'b0, 1'b0);
    expect_pf(1'b1, G + 80, "R8 touched entry kept");
    grant();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule